// File: doc/BRIEF.md
# CAN Fault Confinement and Bus-Off Recovery

This block keeps the transmit and receive error counters of a single CAN node and sequences its entry into, and return from, the bus-off state. Upstream protocol logic sends one-cycle pulses that mark a detected error or an error-free transfer on either direction. A strobe marks each sampled receive bit. A small write port lets software change the reset-mode bit and, while that bit is set, load either counter.

When the transmit counter is already at its ceiling and one more transmit error arrives, the node goes bus-off. It reloads the counters, sets the reset-mode bit and raises the interrupt requests that are enabled. Recovery begins only after software clears reset mode. From then on, every bus-free period (11 recessive bits in a row) lowers the transmit counter by one, until a total of 128 periods have passed. While the node is bus-off, software can cut this short by writing the transmit counter. One bus-free period after reset mode is cleared is then enough.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, both counters read 0, the bus-off and error status flags are 0, reset mode is 1, and both interrupt outputs are 0.
- R2: When reset mode is 0 and the node is operational, an error pulse raises its counter by one and a success pulse lowers it by one. An error pulse and a success pulse on the same counter in the same cycle count as an error.
- R3: Neither counter drops below 0. The receive counter stays at 255 when it gets further errors.
- R4: A transmit error while the transmit counter is 255 puts the node into bus-off one cycle later. At that point the bus-off flag, the error status flag and reset mode are 1, the transmit counter is 127 and the receive counter is 0. The bus-error interrupt pulses for one cycle if its enable is 1, and the error interrupt does the same if its enable is 1.
- R5: Error and success pulses do not change either counter in three cases: while reset mode is 1, while the node is bus-off, and while it waits for its single bus-free period after a shortened recovery.
- R6: Writes to the counters take effect only while reset mode is 1. Otherwise they are ignored.
- R7: While reset mode is 1 and the node is not bus-off, writing 255 to the transmit counter causes the same bus-off entry as R4.
- R8: A bus-free condition is 11 consecutive strobed recessive (1) bits. A dominant (0) bit restarts the run, the run restarts after each detected condition, and it is held at zero while reset mode is 1.
- R9: Bus-off recovery runs only while reset mode is 0. Each bus-free condition lowers the transmit counter by one. A bus-free condition that finds the counter at 0 ends bus-off: the bus-off and error status flags clear and the error interrupt pulses if it is enabled. Starting from 127, this takes 128 conditions.
- R10: While the node is bus-off with reset mode 1, writing a value from 0 to 254 to the transmit counter loads that value and clears bus-off at once. After reset mode is cleared, one bus-free condition clears the error status flag, pulses the error interrupt if it is enabled, and restores normal counting.
- R11: A reset-mode write sets the bit to the written value. Bus-off entry in the same cycle overrides the write and forces the bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err | input | 1 | Transmit error pulse |
| tx_ok | input | 1 | Error-free transmit pulse |
| rx_err | input | 1 | Receive error pulse |
| rx_ok | input | 1 | Error-free receive pulse |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| bit_stb | input | 1 | One pulse per bit time, qualifies rx_bit |
| wr_rm | input | 1 | Write strobe for the reset-mode bit |
| wr_rm_val | input | 1 | Value written to reset mode |
| wr_tec | input | 1 | Write strobe for the transmit counter |
| wr_rec | input | 1 | Write strobe for the receive counter |
| wr_data | input | CW | Value for counter writes |
| beie | input | 1 | Bus-error interrupt enable |
| eie | input | 1 | Error interrupt enable |
| tec | output | CW | Transmit error counter |
| rec | output | CW | Receive error counter |
| bus_off | output | 1 | Bus-off status |
| err_stat | output | 1 | Error status |
| reset_mode | output | 1 | Reset-mode bit |
| bus_err_irq | output | 1 | One-cycle bus-error interrupt request |
| err_irq | output | 1 | One-cycle error interrupt request |

## Verification
Every output is a register. Any pulse, strobe or write sampled at a rising edge shows its effect on the counters, the flags and the interrupt pulses right after that edge. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It reads the result at that same point, half a cycle after the edge that consumed the stimulus. Interrupt pulses are checked at that point, and again one cycle later to confirm they have dropped. For bus-free detection the result is due after the 11th recessive strobe, so the bench sends whole bits through a one-cycle task and checks only after the last bit of each run.

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int CW        = 8,
  parameter int FREE_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_err,
  input  logic          tx_ok,
  input  logic          rx_err,
  input  logic          rx_ok,
  input  logic          rx_bit,
  input  logic          bit_stb,
  input  logic          wr_rm,
  input  logic          wr_rm_val,
  input  logic          wr_tec,
  input  logic          wr_rec,
  input  logic [CW-1:0] wr_data,
  input  logic          beie,
  input  logic          eie,
  output logic [CW-1:0] tec,
  output logic [CW-1:0] rec,
  output logic          bus_off,
  output logic          err_stat,
  output logic          reset_mode,
  output logic          bus_err_irq,
  output logic          err_irq
);
  localparam logic [CW-1:0] MAXV  = {CW{1'b1}};
  localparam logic [CW-1:0] LOADV = {1'b0, {(CW-1){1'b1}}};
  localparam int            RW    = $clog2(FREE_BITS + 1);
  localparam logic [RW-1:0] RLAST = RW'(FREE_BITS - 1);

  logic          wait_q;
  logic [RW-1:0] run_q;

  wire oper       = !reset_mode && !bus_off && !wait_q;
  wire wr_ok      = reset_mode;
  wire enter_err  = oper && tx_err && (tec == MAXV);
  wire enter_wr   = wr_ok && wr_tec && (wr_data == MAXV) && !bus_off;
  wire enter      = enter_err || enter_wr;
  wire short_wr   = wr_ok && wr_tec && (wr_data != MAXV) && bus_off;
  wire bus_free   = bit_stb && rx_bit && (run_q == RLAST) && !reset_mode;
  wire rec_step   = bus_off && !reset_mode && bus_free;
  wire done_long  = rec_step && (tec == '0);
  wire done_short = wait_q && !reset_mode && bus_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             run_q <= '0;
    else if (reset_mode || bus_free)        run_q <= '0;
    else if (bit_stb && !rx_bit)            run_q <= '0;
    else if (bit_stb)                       run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tec <= '0;
    else if (enter) tec <= LOADV;
    else if (wr_ok && wr_tec && wr_data != MAXV) tec <= wr_data;
    else if (rec_step && tec != '0) tec <= tec - 1'b1;
    else if (oper && tx_err) tec <= tec + 1'b1;
    else if (oper && tx_ok && tec != '0) tec <= tec - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec <= '0;
    else if (enter) rec <= '0;
    else if (wr_ok && wr_rec) rec <= wr_data;
    else if (oper && rx_err) begin
      if (rec != MAXV) rec <= rec + 1'b1;
    end
    else if (oper && rx_ok && rec != '0) rec <= rec - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_off     <= 1'b0;
      err_stat    <= 1'b0;
      wait_q      <= 1'b0;
      reset_mode  <= 1'b1;
      bus_err_irq <= 1'b0;
      err_irq     <= 1'b0;
    end else begin
      bus_err_irq <= enter && beie;
      err_irq     <= eie && (enter || done_long || done_short);
      if (enter) begin
        bus_off    <= 1'b1;
        err_stat   <= 1'b1;
        wait_q     <= 1'b0;
        reset_mode <= 1'b1;
      end else begin
        if (wr_rm) reset_mode <= wr_rm_val;
        if (short_wr) begin
          bus_off <= 1'b0;
          wait_q  <= 1'b1;
        end
        if (done_long) begin
          bus_off  <= 1'b0;
          err_stat <= 1'b0;
        end
        if (done_short) begin
          wait_q   <= 1'b0;
          err_stat <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_err,
  input logic          rx_err,
  input logic          wr_tec,
  input logic          wr_rec,
  input logic [CW-1:0] tec,
  input logic [CW-1:0] rec,
  input logic          bus_off,
  input logic          reset_mode,
  input logic          bus_err_irq,
  input logic          err_irq
);
  localparam logic [CW-1:0] MAXV  = {CW{1'b1}};
  localparam logic [CW-1:0] LOADV = {1'b0, {(CW-1){1'b1}}};

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_mode && !bus_off) |=>
      (bus_off || tec == $past(tec) || tec == $past(tec) + 1'b1 || tec == $past(tec) - 1'b1));

  p_rec_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_mode && rec == MAXV && rx_err && !tx_err) |=> rec == MAXV);

  p_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_mode && !bus_off && tx_err && tec == MAXV) |=>
      (bus_off && reset_mode && tec == LOADV && rec == '0));

  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_irq |=> !bus_err_irq);

  p_err_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);

  p_tec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_mode && !wr_tec) |=> tec == $past(tec));

  p_rec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_mode && !wr_tec && !wr_rec) |=> $stable(rec));

  p_busoff_rm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && reset_mode && !wr_tec) |=> bus_off);
endmodule

bind can_fault_conf can_fault_conf_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .rx_err(rx_err),
  .wr_tec(wr_tec), .wr_rec(wr_rec), .tec(tec), .rec(rec),
  .bus_off(bus_off), .reset_mode(reset_mode),
  .bus_err_irq(bus_err_irq), .err_irq(err_irq)
);

// File: tb/can_fault_conf_tb_top.sv
`timescale 1ns/1ps
module can_fault_conf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, rx_bit = 1, bit_stb = 0;
  logic wr_rm = 0, wr_rm_val = 0, wr_tec = 0, wr_rec = 0, beie = 0, eie = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] tec, rec;
  logic bus_off, err_stat, reset_mode, bus_err_irq, err_irq;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  can_fault_conf dut_i (.*);

  // {tx_err, tx_ok, rx_err, rx_ok, exp_tec, exp_rec}
  localparam bit [19:0] VEC [10] = '{
    {4'b1000, 8'd1, 8'd0}, {4'b1010, 8'd2, 8'd1}, {4'b0010, 8'd2, 8'd2},
    {4'b0101, 8'd1, 8'd1}, {4'b1100, 8'd2, 8'd1}, {4'b0100, 8'd1, 8'd1},
    {4'b0100, 8'd0, 8'd1}, {4'b0101, 8'd0, 8'd0}, {4'b0101, 8'd0, 8'd0},
    {4'b0010, 8'd0, 8'd1}};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ev(bit te, bit to, bit re, bit ro);
    @(negedge clk);
    {tx_err, tx_ok, rx_err, rx_ok} = {te, to, re, ro};
    @(negedge clk);
    {tx_err, tx_ok, rx_err, rx_ok} = 4'b0;
  endtask

  task automatic wr(bit rm_s, bit rm_v, bit t_s, bit r_s, logic [7:0] d);
    @(negedge clk);
    {wr_rm, wr_rm_val, wr_tec, wr_rec} = {rm_s, rm_v, t_s, r_s};
    wr_data = d;
    @(negedge clk);
    {wr_rm, wr_tec, wr_rec} = 3'b0;
  endtask

  task automatic send_bit(bit b);
    @(negedge clk);
    bit_stb = 1'b1; rx_bit = b;
    @(negedge clk);
    bit_stb = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic send_free();
    for (int i = 0; i < 11; i++) send_bit(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0);
    chk("R1 bus_off", bus_off, 0); chk("R1 err_stat", err_stat, 0);
    chk("R1 reset_mode", reset_mode, 1);
    chk("R1 irqs", {bus_err_irq, err_irq}, 0);

    wr(1, 0, 0, 0, 8'd0);
    chk("R11 rm cleared", reset_mode, 0);

    for (int i = 0; i < 10; i++) begin
      ev(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      chk($sformatf("R2/R3 vec%0d tec", i), tec, VEC[i][15:8]);
      chk($sformatf("R2/R3 vec%0d rec", i), rec, VEC[i][7:0]);
    end

    wr(0, 0, 1, 1, 8'd200);
    chk("R6 tec write ignored", tec, 0);
    chk("R6 rec write ignored", rec, 1);

    wr(1, 1, 0, 0, 8'd0);
    chk("R11 rm set", reset_mode, 1);
    ev(1, 0, 1, 0);
    chk("R5 tec frozen in reset mode", tec, 0);
    chk("R5 rec frozen in reset mode", rec, 1);

    wr(0, 0, 1, 1, 8'd254);
    chk("R6 tec written", tec, 254); chk("R6 rec written", rec, 254);
    wr(1, 0, 0, 0, 8'd0);
    ev(0, 0, 1, 0); chk("R2 rec to 255", rec, 255);
    ev(0, 0, 1, 0); chk("R3 rec saturates", rec, 255);
    ev(1, 0, 0, 0); chk("R2 tec to 255", tec, 255);
    chk("R2 no bus-off yet", bus_off, 0);

    beie = 1; eie = 1;
    ev(1, 0, 0, 0);
    chk("R4 bus_off", bus_off, 1); chk("R4 err_stat", err_stat, 1);
    chk("R4 reset_mode", reset_mode, 1);
    chk("R4 tec", tec, 127); chk("R4 rec", rec, 0);
    chk("R4 bus_err_irq", bus_err_irq, 1); chk("R4 err_irq", err_irq, 1);
    @(negedge clk);
    chk("R4 irqs drop", {bus_err_irq, err_irq}, 0);

    ev(0, 1, 0, 0);
    chk("R5 tec frozen in bus-off", tec, 127);
    send_free();
    chk("R8 run held in reset mode", tec, 127);

    wr(1, 0, 0, 0, 8'd0);
    chk("R9 still bus-off after rm clear", bus_off, 1);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    chk("R8 dominant restarts run", tec, 127);
    send_bit(1'b1);
    chk("R8 first bus-free", tec, 126);
    for (int i = 0; i < 126; i++) send_free();
    chk("R9 tec at zero", tec, 0);
    chk("R9 bus_off before last period", bus_off, 1);
    send_free();
    chk("R9 bus_off cleared", bus_off, 0);
    chk("R9 err_stat cleared", err_stat, 0);
    chk("R9 err_irq", err_irq, 1);
    chk("R9 no bus_err_irq", bus_err_irq, 0);
    ev(1, 0, 0, 0);
    chk("R9 counting resumes", tec, 1);

    wr(1, 1, 0, 0, 8'd0);
    wr(0, 0, 1, 0, 8'd255);
    chk("R7 forced bus_off", bus_off, 1);
    chk("R7 tec loaded", tec, 127);
    chk("R7 err_irq", err_irq, 1);
    wr(0, 0, 1, 0, 8'd5);
    chk("R10 bus_off cleared by write", bus_off, 0);
    chk("R10 tec written", tec, 5);
    chk("R10 err_stat held", err_stat, 1);
    wr(1, 0, 0, 0, 8'd0);
    ev(1, 0, 0, 0);
    chk("R5 frozen while awaiting bus-free", tec, 5);
    send_free();
    chk("R10 err_stat cleared", err_stat, 0);
    chk("R10 err_irq", err_irq, 1);
    ev(1, 0, 0, 0);
    chk("R10 counting resumes", tec, 6);

    @(negedge clk);
    wr_rm = 1; wr_rm_val = 0;
    wr_tec = 1; wr_data = 8'd255;
    @(negedge clk);
    wr_rm = 0; wr_tec = 0;
    chk("R6 write ignored with rm=0", tec, 6);
    chk("R11 rm write applied", reset_mode, 0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule